// File: doc/BRIEF.md
# CGMS Copy-Control Word Formatter

This block builds the 20-bit copy-generation management word that is inserted on a vertical-blanking line of an NTSC picture. It also decides, one field at a time, whether wide-screen signalling may be sent on a PAL picture. A control byte supplies the following: the four trailing payload bits, a choice between a computed and a stored check field, separate enables for odd and even fields, and a wide-screen enable. Ten further leading payload bits and a stored 6-bit check value come from neighbouring registers.

At every field-start pulse the block captures a complete word and the per-field insert decisions. Register writes made later in the field therefore cannot disturb the word being sent. The word is then shifted out most significant bit first, one bit for each strobe from the upstream line-timing logic. The check field goes last. When the computed check is selected, a 6-bit CRC is formed over the 14 payload bits. It uses the generator x^6 + x + 1 with the register preset to all ones, and the payload is fed in transmit order.

Top module: `cgms_formatter`

## Requirements
- R1: The captured word holds `lead_bits[9:0]` in bits 19:10, `ctrl_reg[3:0]` in bits 9:6 and the check field in bits 5:0. It is shown on `cgms_word` and transmitted from bit 19 down to bit 0.
- R2: When `ctrl_reg[4]` is 1 at field start, bits 5:0 are the CRC of payload bits 19:6 (generator x^6+x+1, preset 6'h3F, bit 19 entered first).
- R3: When `ctrl_reg[4]` is 0 at field start, bits 5:0 equal `crc_reg` unchanged.
- R4: With `std_pal` 0, `cgms_ins_en` is set from `ctrl_reg[5]` when `field_odd` is 1 and from `ctrl_reg[6]` when `field_odd` is 0.
- R5: With `std_pal` 1, `cgms_ins_en` is 0 and no transmission starts, whatever `ctrl_reg[6:5]` hold.
- R6: `wss_en` is 1 only when `std_pal` is 1 and `ctrl_reg[7]` is 1. In NTSC, `ctrl_reg[7]` is ignored.
- R7: While `cgms_active` is 1, `cgms_bit` presents the current word bit and each `bit_strobe` advances to the next one. After the 20th strobe `cgms_active` drops, and later strobes have no effect.
- R8: The word and both enables change only at a field-start pulse. Input changes during a field alter neither them nor the bits still to be sent.
- R9: After reset, `cgms_word`, `cgms_ins_en`, `wss_en`, `cgms_active` and `cgms_bit` are all 0.
- R10: A field-start pulse that arrives during a transmission restarts it at bit 19 of the newly captured word. If a strobe arrives in the same cycle, the field start takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| field_odd | input | 1 | 1 when the starting field is odd |
| std_pal | input | 1 | 1 for PAL, 0 for NTSC |
| ctrl_reg | input | 8 | Control byte: [3:0] trailing payload, [4] computed check, [5] odd enable, [6] even enable, [7] wide-screen enable |
| lead_bits | input | 10 | Leading ten payload bits |
| crc_reg | input | 6 | Stored check value used when [4] is 0 |
| bit_strobe | input | 1 | One pulse per transmitted bit period |
| cgms_word | output | 20 | Word captured at the last field start |
| cgms_ins_en | output | 1 | CGMS insertion enabled for this field |
| wss_en | output | 1 | Wide-screen signalling enabled for this field |
| cgms_active | output | 1 | A word is being shifted out |
| cgms_bit | output | 1 | Current serial bit, 0 when idle |

## Verification
On every cycle the assertions check four things. The bit index stays inside the word while sending. The transmitter goes idle after the last strobe. The captured word and enables move only on a field start. A PAL field never enables CGMS and an NTSC field never enables wide-screen signalling. Three things only the bench scenarios can show: the actual CRC values for a range of payloads, the exact bit order on the serial output, and that a mid-field register rewrite leaves the remaining bits of a transmission untouched. The same holds for restart on an early field start.

// File: rtl/cgms_pkg.sv
// Shared sizes and control-byte field positions for the CGMS formatter.
// Assumes a 14-bit payload followed by a 6-bit check field.
package cgms_pkg;
    localparam int CGMS_DATA_W = 14;
    localparam int CGMS_CRC_W  = 6;
    localparam int CGMS_TAIL_W = 4;
    localparam int CGMS_WORD_W = CGMS_DATA_W + CGMS_CRC_W;
    localparam int CGMS_LEAD_W = CGMS_DATA_W - CGMS_TAIL_W;

    // Generator x^6 + x + 1 without the leading term, preset all ones.
    localparam logic [CGMS_CRC_W-1:0] CGMS_POLY = 6'b000011;
    localparam logic [CGMS_CRC_W-1:0] CGMS_INIT = 6'b111111;

    // Control byte field positions (decoded by the register neighbour).
    localparam int CTL_CRC_SEL = 4;
    localparam int CTL_ODD_EN  = 5;
    localparam int CTL_EVEN_EN = 6;
    localparam int CTL_WSS_EN  = 7;

    typedef struct packed {
        logic cgms;
        logic wss;
    } field_en_t;
endpackage

// File: rtl/cgms_crc6.sv
// Serial-equivalent CRC over a parallel payload.
// Unrolls one LFSR step per payload bit, most significant bit first.
// Assumes the polynomial is given without its leading term.
module cgms_crc6 #(
    parameter int DATA_W = cgms_pkg::CGMS_DATA_W,
    parameter int CRC_W  = cgms_pkg::CGMS_CRC_W,
    parameter logic [CRC_W-1:0] POLY = cgms_pkg::CGMS_POLY,
    parameter logic [CRC_W-1:0] INIT = cgms_pkg::CGMS_INIT
) (
    input  logic [DATA_W-1:0] payload,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] stage [0:DATA_W];

    assign stage[0] = INIT;

    // One shift step per payload bit, in transmit order.
    for (genvar g = 0; g < DATA_W; g++) begin : g_step
        logic fb;
        assign fb = payload[DATA_W-1-g] ^ stage[g][CRC_W-1];
        assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc = stage[DATA_W];
endmodule

// File: rtl/cgms_field_latch.sv
// Captures the full word and the per-field insert decisions at field start.
// Assumes field_start is a single-cycle pulse; holds everything otherwise.
module cgms_field_latch
    import cgms_pkg::*;
#(
    parameter int DATA_W = CGMS_DATA_W,
    parameter int CRC_W  = CGMS_CRC_W,
    localparam int WORD_W = DATA_W + CRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              std_pal,
    input  logic [7:0]        ctrl_reg,
    input  logic [DATA_W-1:0] payload,
    input  logic [CRC_W-1:0]  crc_reg,
    input  logic [CRC_W-1:0]  crc_calc,
    output logic [WORD_W-1:0] word_q,
    output field_en_t         en_q,
    output logic              cgms_en_next
);
    logic [CRC_W-1:0] crc_pick;
    logic             wss_en_next;

    // Choose the check field source.
    always_comb crc_pick = ctrl_reg[CTL_CRC_SEL] ? crc_calc : crc_reg;

    // Decide per-field enables from standard and parity.
    always_comb begin
        cgms_en_next = !std_pal &&
                       (field_odd ? ctrl_reg[CTL_ODD_EN] : ctrl_reg[CTL_EVEN_EN]);
        wss_en_next  = std_pal && ctrl_reg[CTL_WSS_EN];
    end

    // Capture word and enables once per field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            en_q   <= '0;
        end else if (field_start) begin
            word_q   <= {payload, crc_pick};
            en_q.cgms <= cgms_en_next;
            en_q.wss  <= wss_en_next;
        end
    end

    p_pal_no_cgms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && std_pal |=> !en_q.cgms);
    p_ntsc_no_wss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && !std_pal |=> !en_q.wss);
    p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(word_q) && $stable(en_q));
    p_crc_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && !ctrl_reg[CTL_CRC_SEL] |=> word_q[CRC_W-1:0] == $past(crc_reg));
endmodule

// File: rtl/cgms_serializer.sv
// Shifts a held word out MSB first, one bit per strobe.
// Assumes the word is stable while active; a start overrides a strobe.
module cgms_serializer #(
    parameter int WORD_W = cgms_pkg::CGMS_WORD_W,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_en,
    input  logic              strobe,
    input  logic [WORD_W-1:0] word,
    output logic              active,
    output logic              ser_bit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sel;

    // Advance bit index, start or end a transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= start_en;
            idx    <= '0;
        end else if (active && strobe) begin
            if (idx == LAST) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Pick the current bit, most significant first.
    always_comb begin
        sel     = LAST - idx;
        ser_bit = active ? word[sel] : 1'b0;
    end

    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> idx <= LAST);
    p_ends_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active && strobe && !start && idx == LAST |=> !active);
    p_restart_at_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> idx == '0);
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !start |=> !active);
endmodule

// File: rtl/cgms_formatter.sv
// Top of the CGMS copy-control formatter: CRC, per-field capture, serial out.
// Assumes field_start and bit_strobe come from upstream line timing.
module cgms_formatter
    import cgms_pkg::*;
#(
    parameter int DATA_W = CGMS_DATA_W,
    parameter int CRC_W  = CGMS_CRC_W,
    parameter int TAIL_W = CGMS_TAIL_W,
    localparam int LEAD_W = DATA_W - TAIL_W,
    localparam int WORD_W = DATA_W + CRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              std_pal,
    input  logic [7:0]        ctrl_reg,
    input  logic [LEAD_W-1:0] lead_bits,
    input  logic [CRC_W-1:0]  crc_reg,
    input  logic              bit_strobe,
    output logic [WORD_W-1:0] cgms_word,
    output logic              cgms_ins_en,
    output logic              wss_en,
    output logic              cgms_active,
    output logic              cgms_bit
);
    logic [DATA_W-1:0] payload;
    logic [CRC_W-1:0]  crc_calc;
    field_en_t         en_q;
    logic              cgms_en_next;

    // Join leading bits with the trailing control-byte bits.
    always_comb payload = {lead_bits, ctrl_reg[TAIL_W-1:0]};

    cgms_crc6 #(.DATA_W(DATA_W), .CRC_W(CRC_W)) crc_i (
        .payload (payload),
        .crc     (crc_calc)
    );

    cgms_field_latch #(.DATA_W(DATA_W), .CRC_W(CRC_W)) latch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start  (field_start),
        .field_odd    (field_odd),
        .std_pal      (std_pal),
        .ctrl_reg     (ctrl_reg),
        .payload      (payload),
        .crc_reg      (crc_reg),
        .crc_calc     (crc_calc),
        .word_q       (cgms_word),
        .en_q         (en_q),
        .cgms_en_next (cgms_en_next)
    );

    cgms_serializer #(.WORD_W(WORD_W)) ser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (field_start),
        .start_en (cgms_en_next),
        .strobe   (bit_strobe),
        .word     (cgms_word),
        .active   (cgms_active),
        .ser_bit  (cgms_bit)
    );

    // Expose latched per-field enables.
    always_comb begin
        cgms_ins_en = en_q.cgms;
        wss_en      = en_q.wss;
    end

    p_active_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cgms_active |-> cgms_ins_en);
endmodule

// File: tb/cgms_formatter_tb_top.sv
`timescale 1ns/1ps
module cgms_formatter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic        field_odd = 1'b0;
    logic        std_pal = 1'b0;
    logic [7:0]  ctrl_reg = '0;
    logic [9:0]  lead_bits = '0;
    logic [5:0]  crc_reg = '0;
    logic        bit_strobe = 1'b0;
    logic [19:0] cgms_word;
    logic        cgms_ins_en, wss_en, cgms_active, cgms_bit;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cgms_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
        .std_pal(std_pal), .ctrl_reg(ctrl_reg), .lead_bits(lead_bits),
        .crc_reg(crc_reg), .bit_strobe(bit_strobe), .cgms_word(cgms_word),
        .cgms_ins_en(cgms_ins_en), .wss_en(wss_en), .cgms_active(cgms_active),
        .cgms_bit(cgms_bit)
    );

    // Entry: {pal, odd, ctrl[7:0], lead[9:0], crc[5:0]}
    localparam logic [25:0] VEC [0:6] = '{
        {1'b0, 1'b1, 8'b0011_1010, 10'h2A5, 6'h00},
        {1'b0, 1'b0, 8'b0100_0101, 10'h13C, 6'h2D},
        {1'b0, 1'b1, 8'b1100_0011, 10'h0F0, 6'h11},
        {1'b1, 1'b1, 8'b1111_1111, 10'h3FF, 6'h22},
        {1'b1, 1'b0, 8'b0111_0000, 10'h155, 6'h3F},
        {1'b0, 1'b0, 8'b0101_0000, 10'h000, 6'h05},
        {1'b0, 1'b1, 8'b0011_1111, 10'h3FF, 6'h00}
    };

    // Reference check by long division: preset folded into the top payload bits.
    function automatic logic [5:0] ref_crc(input logic [13:0] pl);
        logic [19:0] m;
        m = {pl ^ 14'h3F00, 6'b0};
        for (int b = 19; b >= 6; b--)
            if (m[b]) m[b -: 7] = m[b -: 7] ^ 7'b1000011;
        return m[5:0];
    endfunction

    function automatic logic [19:0] ref_word(input logic [7:0] c, input logic [9:0] l,
                                             input logic [5:0] r);
        logic [13:0] pl;
        pl = {l, c[3:0]};
        return {pl, c[4] ? ref_crc(pl) : r};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic set_in(input logic pal, input logic odd, input logic [7:0] c,
                          input logic [9:0] l, input logic [5:0] r);
        std_pal = pal; field_odd = odd; ctrl_reg = c; lead_bits = l; crc_reg = r;
    endtask

    task automatic pulse_field();
        field_start = 1'b1; tick(); field_start = 1'b0;
    endtask

    task automatic pulse_strobe();
        bit_strobe = 1'b1; tick(); bit_strobe = 1'b0;
    endtask

    // Shift out n bits starting at position hi, checking each.
    task automatic send_bits(input logic [19:0] w, input int hi, input int n);
        for (int i = 0; i < n; i++) begin
            chk("R7 active", {31'b0, cgms_active}, 32'd1);
            chk("R1 serial bit", {31'b0, cgms_bit}, {31'b0, w[hi - i]});
            pulse_strobe();
        end
    endtask

    initial begin
        #(4.0 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] w, w2;
        logic exp_c, exp_w;
        tick(); tick(); tick();
        // R9 reset state
        chk("R9 word", {12'b0, cgms_word}, 32'd0);
        chk("R9 ins_en", {31'b0, cgms_ins_en}, 32'd0);
        chk("R9 wss_en", {31'b0, wss_en}, 32'd0);
        chk("R9 active", {31'b0, cgms_active}, 32'd0);
        chk("R9 bit", {31'b0, cgms_bit}, 32'd0);
        rst_n = 1'b1; tick();

        // Table walk: R1..R7
        for (int v = 0; v < 7; v++) begin
            set_in(VEC[v][25], VEC[v][24], VEC[v][23:16], VEC[v][15:6], VEC[v][5:0]);
            w = ref_word(ctrl_reg, lead_bits, crc_reg);
            exp_c = !std_pal && (field_odd ? ctrl_reg[5] : ctrl_reg[6]);
            exp_w = std_pal && ctrl_reg[7];
            pulse_field();
            chk(ctrl_reg[4] ? "R2 word crc" : "R3 word crc", {12'b0, cgms_word}, {12'b0, w});
            chk(std_pal ? "R5 ins_en" : "R4 ins_en", {31'b0, cgms_ins_en}, {31'b0, exp_c});
            chk("R6 wss_en", {31'b0, wss_en}, {31'b0, exp_w});
            if (exp_c) begin
                send_bits(w, 19, 20);
                chk("R7 idle after word", {31'b0, cgms_active}, 32'd0);
            end else begin
                chk("R5 no start", {31'b0, cgms_active}, 32'd0);
            end
            pulse_strobe();
            chk("R7 strobe while idle", {30'b0, cgms_active, cgms_bit}, 32'd0);
        end

        // R8: rewrite inputs mid-field
        set_in(1'b0, 1'b1, 8'b0011_0110, 10'h1C3, 6'h00);
        w = ref_word(ctrl_reg, lead_bits, crc_reg);
        pulse_field();
        send_bits(w, 19, 5);
        set_in(1'b1, 1'b0, 8'b1000_1001, 10'h2E7, 6'h1A);
        tick();
        chk("R8 word held", {12'b0, cgms_word}, {12'b0, w});
        chk("R8 ins_en held", {31'b0, cgms_ins_en}, 32'd1);
        chk("R8 wss held", {31'b0, wss_en}, 32'd0);
        send_bits(w, 14, 3);

        // R10: restart mid-word, field start with a simultaneous strobe
        set_in(1'b0, 1'b0, 8'b0101_1100, 10'h0A9, 6'h00);
        w2 = ref_word(ctrl_reg, lead_bits, crc_reg);
        bit_strobe = 1'b1; field_start = 1'b1; tick();
        bit_strobe = 1'b0; field_start = 1'b0;
        chk("R10 new word", {12'b0, cgms_word}, {12'b0, w2});
        chk("R10 restart msb", {31'b0, cgms_bit}, {31'b0, w2[19]});
        send_bits(w2, 19, 20);
        chk("R10 idle after full word", {31'b0, cgms_active}, 32'd0);

        // R3 passthrough with all-ones stored check, NTSC even
        set_in(1'b0, 1'b0, 8'b0100_1111, 10'h3FF, 6'h3F);
        pulse_field();
        chk("R3 stored check", {26'b0, cgms_word[5:0]}, 32'h3F);

        // R9 reset while sending
        send_bits(20'hFFFFF, 19, 1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R9 reset mid-word", {11'b0, cgms_word, cgms_active}, 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule